// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block sequences the bring-up of a programmable device after power-on or after a reprogram request. It holds the device in a memory-clearing state while the active-low program request is low, moves to data loading once the clear-complete indication arrives, and then runs eight numbered start-up phases. During these phases the global controls are released in a fixed staggered order: DONE first, then the output three-state hold, then the write-enable hold.

Global set/reset stays high through clearing and loading. It gives one final pulse in start-up phase 0 so that all storage starts from a known value. An optional synchronous mode makes the three-state and write-enable release steps wait until the externally sensed DONE line is actually high. This covers boards where another agent may hold DONE low.

All outputs are active-high. `init_en` high means the block pulls the INIT line low. Releasing it lets an external resistor pull the line high. `gts_hold` and `gwe_hold` high mean outputs are tri-stated and writes are blocked.

Top module: `cfg_startup_seq`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, the block is in the clearing state. The outputs are then {init_en,done_rel,gsr,gts_hold,gwe_hold} = 1,0,1,1,1.
- R2: When prog_n is low at a clock edge, from any state, the next cycle shows the clearing state with outputs 1,0,1,1,1.
- R3: In the clearing state the block leaves only when prog_n and clear_done are both high at an edge. It then enters loading, where init_en is 0. load_done has no effect while clearing.
- R4: In loading, gsr, gts_hold and gwe_hold stay high and done_rel stays low until load_done is high at an edge. That edge starts phase 0. clear_done has no effect while loading.
- R5: gsr is high in phase 0 and low in every later phase.
- R6: Without a stall, the phase advances by one per clock from 0 to 7 and then stays at 7.
- R7: done_rel is high in phases 4 and above and low everywhere else.
- R8: gts_hold goes low from phase 5 on, and gwe_hold goes low from phase 6 on. In default mode each release follows the previous one by exactly one clock.
- R9: With sync_mode high, the phase stays at 4 and at 5 for as long as done_sense is low. It moves on at the first edge where done_sense is high.
- R10: done_sense has no effect in phases other than 4 and 5, and no effect at all when sync_mode is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Start-up clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_n | input | 1 | Active-low program request; restarts the flow |
| clear_done | input | 1 | Configuration memory clear has finished |
| load_done | input | 1 | Configuration data load has finished |
| sync_mode | input | 1 | Stall the later release steps until DONE is sensed high |
| done_sense | input | 1 | Sensed level of the external DONE line |
| init_en | output | 1 | 1 = pull INIT low (clearing in progress) |
| done_rel | output | 1 | 1 = DONE released |
| gsr | output | 1 | Global set/reset active |
| gts_hold | output | 1 | Global three-state held |
| gwe_hold | output | 1 | Global write enable held off |

## Verification
The assertions assume that reset is applied at time zero. They also assume that prog_n, clear_done, load_done, sync_mode and done_sense are stable around each rising edge, and do not assume any ordering among those inputs. The stimulus changes every input only on the falling clock edge and holds it over the next rising edge. Handshake inputs are left high while the flow has moved past the state that uses them, so the block sees stale indications, which it must ignore. done_sense is toggled freely in both modes, including during phases where it must have no effect.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int PHASE_W  = 3;
    localparam int LAST_PH  = (1 << PHASE_W) - 1;
    localparam int DONE_PH  = 4;
    localparam int GTS_PH   = DONE_PH + 1;
    localparam int GWE_PH   = GTS_PH + 1;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic [1:0] {
        FL_CLEAR   = 2'd0,
        FL_LOAD    = 2'd1,
        FL_STARTUP = 2'd2
    } flow_t;

    typedef struct packed {
        logic init_en;
        logic done_rel;
        logic gsr;
        logic gts_hold;
        logic gwe_hold;
    } glob_t;

    // Phase at which the sequence may be held by the sensed DONE level.
    function automatic logic is_sync_gate(phase_t ph);
        return (ph == phase_t'(DONE_PH)) || (ph == phase_t'(GTS_PH));
    endfunction

    function automatic glob_t glob_of(flow_t st, phase_t ph);
        glob_t g;
        g.init_en  = (st == FL_CLEAR);
        g.done_rel = (st == FL_STARTUP) && (ph >= phase_t'(DONE_PH));
        g.gsr      = (st != FL_STARTUP) || (ph == '0);
        g.gts_hold = !((st == FL_STARTUP) && (ph >= phase_t'(GTS_PH)));
        g.gwe_hold = !((st == FL_STARTUP) && (ph >= phase_t'(GWE_PH)));
        return g;
    endfunction

endpackage

// File: rtl/cfg_flow_ctl.sv
module cfg_flow_ctl
    import cfg_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  prog_n,
    input  logic  clear_done,
    input  logic  load_done,
    output flow_t state
);

    flow_t nxt;

    always_comb begin
        nxt = state;
        if (!prog_n) begin
            nxt = FL_CLEAR;
        end else begin
            unique case (state)
                FL_CLEAR:   if (clear_done) nxt = FL_LOAD;
                FL_LOAD:    if (load_done)  nxt = FL_STARTUP;
                FL_STARTUP: nxt = FL_STARTUP;
                default:    nxt = FL_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FL_CLEAR;
        else     state <= nxt;
    end

    assert_prog_restart_R2: assert property (@(posedge clk) disable iff (rst)
        !prog_n |=> state == FL_CLEAR);

    assert_load_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (state == FL_LOAD) && $past(state) != FL_LOAD |-> $past(state) == FL_CLEAR);

    assert_startup_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (state == FL_STARTUP) && $past(state) != FL_STARTUP |-> $past(state) == FL_LOAD);

endmodule

// File: rtl/cfg_phase_cnt.sv
module cfg_phase_cnt
    import cfg_seq_pkg::*;
#(
    parameter bit SYNC_GATE_EN = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   sync_mode,
    input  logic   done_sense,
    output phase_t phase
);

    logic stall;

    generate
        if (SYNC_GATE_EN) begin : g_sync
            always_comb stall = sync_mode && !done_sense && is_sync_gate(phase);
        end else begin : g_nosync
            logic unused_ok;
            always_comb unused_ok = sync_mode ^ done_sense;
            always_comb stall = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run)
            phase <= '0;
        else if (phase != phase_t'(LAST_PH) && !stall)
            phase <= phase + 1'b1;
    end

    assert_phase_step_R6: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) && phase != $past(phase) |-> phase == $past(phase) + 1'b1);

    assert_phase_hold_last_R6: assert property (@(posedge clk) disable iff (rst)
        run && phase == phase_t'(LAST_PH) |=> !run || phase == phase_t'(LAST_PH));

endmodule

// File: rtl/cfg_glob_drv.sv
module cfg_glob_drv
    import cfg_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flow_t  state,
    input  phase_t phase,
    output glob_t  glob
);

    always_comb glob = glob_of(state, phase);

    assert_gwe_after_gts_R8: assert property (@(posedge clk) disable iff (rst)
        !glob.gwe_hold |-> !glob.gts_hold);

    assert_gts_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(glob.gts_hold) |-> $past(glob.done_rel));

    assert_gwe_fall_order_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(glob.gwe_hold) |-> $past(!glob.gts_hold));

    assert_gsr_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(glob.gsr) |-> state == FL_STARTUP && $past(state) == FL_STARTUP);

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
    import cfg_seq_pkg::*;
#(
    parameter bit SYNC_GATE_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_n,
    input  logic clear_done,
    input  logic load_done,
    input  logic sync_mode,
    input  logic done_sense,
    output logic init_en,
    output logic done_rel,
    output logic gsr,
    output logic gts_hold,
    output logic gwe_hold
);

    flow_t  state;
    phase_t phase;
    glob_t  glob;
    logic   run;

    cfg_flow_ctl u_flow (
        .clk        (clk),
        .rst        (rst),
        .prog_n     (prog_n),
        .clear_done (clear_done),
        .load_done  (load_done),
        .state      (state)
    );

    always_comb run = (state == FL_STARTUP) && prog_n;

    cfg_phase_cnt #(.SYNC_GATE_EN(SYNC_GATE_EN)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .sync_mode  (sync_mode),
        .done_sense (done_sense),
        .phase      (phase)
    );

    cfg_glob_drv u_glob (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .phase (phase),
        .glob  (glob)
    );

    always_comb begin
        init_en  = glob.init_en;
        done_rel = glob.done_rel;
        gsr      = glob.gsr;
        gts_hold = glob.gts_hold;
        gwe_hold = glob.gwe_hold;
    end

    assert_sync_stall_R9: assert property (@(posedge clk) disable iff (rst)
        prog_n && state == FL_STARTUP && sync_mode && !done_sense
        && phase == phase_t'(DONE_PH) |=> phase == phase_t'(DONE_PH));

    assert_prog_outputs_R2: assert property (@(posedge clk) disable iff (rst)
        !prog_n |=> init_en && gsr && gts_hold && gwe_hold && !done_rel);

    assert_done_before_gts_R7: assert property (@(posedge clk) disable iff (rst)
        !gts_hold |-> done_rel);

endmodule

// File: tb/sim_cfg_startup_seq.sv
module sim_cfg_startup_seq;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_n = 1'b0, clear_done = 1'b0, load_done = 1'b0;
    logic sync_mode = 1'b0, done_sense = 1'b0;
    logic init_en, done_rel, gsr, gts_hold, gwe_hold;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cfg_startup_seq u0 (
        .clk(clk), .rst(rst), .prog_n(prog_n), .clear_done(clear_done),
        .load_done(load_done), .sync_mode(sync_mode), .done_sense(done_sense),
        .init_en(init_en), .done_rel(done_rel), .gsr(gsr),
        .gts_hold(gts_hold), .gwe_hold(gwe_hold)
    );

    // Expected output codes {init_en,done_rel,gsr,gts_hold,gwe_hold}
    localparam logic [4:0] O_CLR = 5'b10111;
    localparam logic [4:0] O_LD  = 5'b00111;
    localparam logic [4:0] O_P0  = 5'b00111;
    localparam logic [4:0] O_P13 = 5'b00011;
    localparam logic [4:0] O_P4  = 5'b01011;
    localparam logic [4:0] O_P5  = 5'b01001;
    localparam logic [4:0] O_P67 = 5'b01000;

    // {prog_n,clear_done,load_done,sync_mode,done_sense, expected}
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        {5'b00000, O_CLR},  // R2
        {5'b10000, O_CLR},  // R3 waits
        {5'b11000, O_LD},   // R3 enter load
        {5'b11001, O_LD},   // R4 waits
        {5'b11100, O_P0},   // R4/R5
        {5'b11101, O_P13},  // R5 P1, R10
        {5'b11100, O_P13},
        {5'b11101, O_P13},
        {5'b11100, O_P4},   // R7
        {5'b11100, O_P5},   // R8
        {5'b11100, O_P67},  // R8
        {5'b11100, O_P67},  // R6 P7
        {5'b11101, O_P67},  // R6 hold
        {5'b01100, O_CLR}   // R2
    };

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] got;
        got = {init_en, done_rel, gsr, gts_hold, gwe_hold};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input logic [4:0] in);
        {prog_n, clear_done, load_done, sync_mode, done_sense} = in;
    endtask

    task automatic step(input string req, input logic [4:0] in, input logic [4:0] exp);
        drive(in);
        @(posedge clk);
        @(negedge clk);
        check(req, exp);
    endtask

    initial begin
        #(4 * 5000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R1 in reset", O_CLR);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 after reset", O_CLR);

        for (int i = 0; i < NV; i++) begin
            step($sformatf("table row %0d (R2..R8)", i), VEC[i][9:5], VEC[i][4:0]);
        end

        // R3: load_done ignored while clearing
        step("R3 load_done ignored", 5'b10100, O_CLR);
        step("R3 load_done ignored 2", 5'b10100, O_CLR);
        step("R3 to load", 5'b11000, O_LD);
        // R2: program request from loading
        step("R2 from load", 5'b01000, O_CLR);

        // R9: sync mode stalls at phases 4 and 5
        step("R3 to load", 5'b11010, O_LD);
        step("R4 to P0", 5'b11110, O_P0);
        step("R10 P1 sync no stall", 5'b11110, O_P13);
        step("R10 P2 sync no stall", 5'b11110, O_P13);
        step("R10 P3 sync no stall", 5'b11110, O_P13);
        step("R7 P4", 5'b11110, O_P4);
        for (int k = 0; k < 3; k++) step("R9 stall at P4", 5'b11110, O_P4);
        step("R9 release to P5", 5'b11111, O_P5);
        step("R9 stall at P5", 5'b11110, O_P5);
        step("R9 stall at P5 2", 5'b11110, O_P5);
        step("R9 release to P6", 5'b11111, O_P67);
        step("R10 P7 with sense low", 5'b11110, O_P67);
        step("R6 stay P7", 5'b11110, O_P67);

        // R2 during phase 5 in default mode
        step("R2 restart", 5'b00000, O_CLR);
        step("R3 load", 5'b11000, O_LD);
        step("R4 clear_done ignored", 5'b11000, O_LD);
        step("R4 P0", 5'b11100, O_P0);
        step("R6 P1", 5'b11100, O_P13);
        step("R6 P2", 5'b11100, O_P13);
        step("R6 P3", 5'b11100, O_P13);
        step("R10 P4 default sense low", 5'b11100, O_P4);
        step("R10 P5 default sense low", 5'b11100, O_P5);
        step("R2 from P5", 5'b01100, O_CLR);

        // R1: reset from a running state
        step("R3 load", 5'b11000, O_LD);
        step("R4 P0", 5'b11100, O_P0);
        rst = 1'b1;
        step("R1 reset mid-flow", 5'b11100, O_CLR);
        rst = 1'b0;
        step("R1 released, clear_done seen", 5'b11100, O_LD);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule